// File: doc/BRIEF.md
# Multiplier Self-Test Controller with Reference Comparator

This block runs a built-in self-test on an 8x8 multiplier that sits outside it. Two 8-bit pseudo-random operand generators, one for each operand, drive the multiplier under test. The same operands go to an internal reference multiplier. Each generator runs either in a plain shift mode or in a low-switching mode, and the mode for each is chosen when the test starts. The product from the multiplier under test and the reference product are each registered in their own 16-bit register and compared one cycle after the pattern is applied. Every pattern is checked against the reference. No signature is compressed.

A sequencer handles a test run. A `start` pulse, accepted while idle or finished, clears the results and latches the pattern count and the mode selection. One seed cycle follows, then one pattern per cycle with `op_valid` high, then one drain cycle that compares the last captured product. After that `done` is raised and held. The results are a sticky fail flag, the 0-based index of the first mismatching pattern and a saturating mismatch count. They stay readable until the next accepted start.

The operand stream has no ready signal, so there is no back-pressure. The multiplier under test must present `mut_product` for the operands shown in the same cycle. The block samples it on the clock edge that ends every cycle in which `op_valid` is high.

Top module: `mbist_mult_top`

## Requirements
- R1: While reset is asserted, and after it is released until a start is accepted, `done`, `fail`, `op_valid`, `first_fail_idx` and `mismatch_cnt` are all zero.
- R2: `start` is accepted only when the block is idle or done. One seed cycle follows, then exactly `pat_count` consecutive cycles with `op_valid` high. A `start` pulse while a run is in progress has no effect on the outputs.
- R3: In plain mode a generator shows its seed (0xA5 for operand a, 0x3C for operand b) as pattern 0. Each later pattern is the previous one shifted left by one, with bit 0 set to the XOR of bits 7, 5, 4 and 3 of the previous pattern (for operand a, pattern 1 is 0x4A).
- R4: In low-switching mode a generator keeps a shift state S, updated by the R3 rule, and a shown pattern P, and steps through four phases in a repeating order. Phase 0 advances S and sets P[3:0] to the old P[3:0] AND the new S[3:0]. Phase 1 sets P[3:0] to S[3:0]. Phase 2 sets P[7:4] to P[7:4] AND S[7:4]. Phase 3 sets P[7:4] to S[7:4]. Only one half of P changes per pattern. For operand a, patterns 0 to 4 are 0xA5, 0xA0, 0xAA, 0x0A, 0x4A.
- R5: `mut_product` is sampled at the end of each cycle with `op_valid` high. It is compared in the following cycle against the product of the operands shown in the sampled cycle. The results change at the end of that comparison cycle.
- R6: `fail` is set by any mismatch and stays high until the next accepted start.
- R7: `first_fail_idx` holds the 0-based pattern index of the first mismatch of the run. It is zero if no mismatch occurred.
- R8: `mismatch_cnt` counts mismatching patterns and holds at its all-ones value instead of wrapping.
- R9: `done` rises in the cycle after the drain cycle, which follows the last pattern cycle. With `pat_count` zero, `done` rises right after the seed cycle. `done` stays high until a start is accepted.
- R10: `lp_sel` is latched at start. Bit 0 selects low-switching mode for operand a and bit 1 for operand b. Changes to `lp_sel` during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (pulse) |
| pat_count | input | 16 | Number of patterns to apply, latched at start |
| lp_sel | input | 2 | Low-switching mode select per generator, latched at start |
| op_valid | output | 1 | Operands are a live test pattern this cycle |
| op_a | output | 8 | Operand a to the multiplier under test |
| op_b | output | 8 | Operand b to the multiplier under test |
| mut_product | input | 16 | Product returned by the multiplier under test |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Sticky mismatch flag |
| first_fail_idx | output | 16 | Index of first mismatching pattern |
| mismatch_cnt | output | MISS_W (16) | Saturating mismatch count |

## Verification
A wrong generator state or phase shows up on `op_a` or `op_b` in the first cycle it occurs, because the bench predicts every operand of every pattern. A fault in the capture register, the pattern index pipeline or the comparator shows up one cycle later on `fail`, `first_fail_idx` or `mismatch_cnt`. Faults are injected at chosen pattern indices, so the exact index and count are known. A sequencer error, such as a pattern count that is off by one, a missing drain or an accepted restart, appears on `op_valid` or `done` in the cycle where the model and the design diverge. The saturating counter is exercised with a narrowed counter width.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/mbist_patgen.sv
module mbist_patgen #(
  parameter int          W    = 8,
  parameter logic [W-1:0] SEED = 8'hA5,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         lp,
  output logic [W-1:0] pattern
);
  localparam int H = W / 2;

  logic [W-1:0] shreg, pat, nxt;
  logic [1:0]   phase;

  assign nxt     = {shreg[W-2:0], ^(shreg & TAPS)};
  assign pattern = pat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= SEED;
      pat   <= SEED;
      phase <= '0;
    end else if (load) begin
      shreg <= SEED;
      pat   <= SEED;
      phase <= '0;
    end else if (step) begin
      if (!lp) begin
        shreg <= nxt;
        pat   <= nxt;
      end else begin
        phase <= phase + 2'd1;
        unique case (phase)
          2'd0: begin
            shreg        <= nxt;
            pat[H-1:0]   <= pat[H-1:0] & nxt[H-1:0];
          end
          2'd1: pat[H-1:0] <= shreg[H-1:0];
          2'd2: pat[W-1:H] <= pat[W-1:H] & shreg[W-1:H];
          default: pat[W-1:H] <= shreg[W-1:H];
        endcase
      end
    end
  end

  // R4: low-switching steps never move both halves at once
  a_r4_one_half: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lp && !load) |=> ($stable(pat[H-1:0]) || $stable(pat[W-1:H])));
  // R3: the shift state never falls into the all-zero lockup
  a_r3_live_state: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (shreg != '0));
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pat_count,
  input  logic [1:0]       lp_sel,
  output logic             clear,
  output logic             load,
  output logic             step,
  output logic [CNT_W-1:0] idx,
  output logic [1:0]       lp_q,
  output logic             done
);
  seq_state_t       state;
  logic [CNT_W-1:0] limit, cnt;

  assign clear = start && (state == ST_IDLE || state == ST_DONE);
  assign load  = (state == ST_SEED);
  assign step  = (state == ST_RUN);
  assign done  = (state == ST_DONE);
  assign idx   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      limit <= '0;
      cnt   <= '0;
      lp_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (clear) begin
          state <= ST_SEED;
          limit <= pat_count;
          lp_q  <= lp_sel;
        end
        ST_SEED: begin
          cnt   <= '0;
          state <= (limit == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == limit - 1'b1) state <= ST_DRAIN;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // R9: done holds until a new start
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R2: a start arriving mid-run is not taken
  a_r2_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (step && start) |=> !load);
  // R10: mode selection frozen while patterns run
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(lp_q));
endmodule

// File: rtl/mbist_result.sv
module mbist_result #(
  parameter int OP_W   = 8,
  parameter int CNT_W  = 16,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [CNT_W-1:0]  idx,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [2*OP_W-1:0] mut_product,
  output logic              fail,
  output logic [CNT_W-1:0]  first_idx,
  output logic [MISS_W-1:0] miss_cnt
);
  localparam int PW = 2 * OP_W;

  logic [PW-1:0]    mut_q, ref_q;
  logic [CNT_W-1:0] idx_q;
  logic             vld_q, mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mut_q <= '0;
      ref_q <= '0;
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= capture;
      if (capture) begin
        mut_q <= mut_product;
        ref_q <= PW'(op_a) * PW'(op_b);
        idx_q <= idx;
      end
    end
  end

  assign mismatch = vld_q && (mut_q != ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      first_idx <= '0;
      miss_cnt  <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      first_idx <= '0;
      miss_cnt  <= '0;
    end else if (mismatch) begin
      fail <= 1'b1;
      if (!fail) first_idx <= idx_q;
      if (miss_cnt != '1) miss_cnt <= miss_cnt + 1'b1;
    end
  end

  // R6: fail is sticky
  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> fail);
  // R7: first index frozen once a failure is recorded
  a_r7_first_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> $stable(first_idx));
  // R8: counter holds at full scale
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt == '1 && !clear) |=> (miss_cnt == '1));
  // R8: a nonzero count implies the fail flag
  a_r8_count_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt != '0) |-> fail);
endmodule

// File: rtl/mbist_mult_top.sv
module mbist_mult_top #(
  parameter int              OP_W   = 8,
  parameter int              CNT_W  = 16,
  parameter int              MISS_W = 16,
  parameter logic [OP_W-1:0] SEED_A = 8'hA5,
  parameter logic [OP_W-1:0] SEED_B = 8'h3C,
  parameter logic [OP_W-1:0] TAPS   = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  pat_count,
  input  logic [1:0]        lp_sel,
  output logic              op_valid,
  output logic [OP_W-1:0]   op_a,
  output logic [OP_W-1:0]   op_b,
  input  logic [2*OP_W-1:0] mut_product,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  first_fail_idx,
  output logic [MISS_W-1:0] mismatch_cnt
);
  localparam int NGEN = 2;
  localparam logic [NGEN*OP_W-1:0] SEEDS = {SEED_B, SEED_A};

  logic             clear, load, step;
  logic [CNT_W-1:0] idx;
  logic [1:0]       lp_q;
  logic [OP_W-1:0]  pats [NGEN];

  mbist_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
    .lp_sel(lp_sel), .clear(clear), .load(load), .step(step),
    .idx(idx), .lp_q(lp_q), .done(done)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    mbist_patgen #(
      .W(OP_W), .SEED(SEEDS[g*OP_W +: OP_W]), .TAPS(TAPS)
    ) u_gen (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .lp(lp_q[g]), .pattern(pats[g])
    );
  end

  assign op_a     = pats[0];
  assign op_b     = pats[1];
  assign op_valid = step;

  mbist_result #(.OP_W(OP_W), .CNT_W(CNT_W), .MISS_W(MISS_W)) u_res (
    .clk(clk), .rst_n(rst_n), .clear(clear), .capture(step), .idx(idx),
    .op_a(op_a), .op_b(op_b), .mut_product(mut_product),
    .fail(fail), .first_idx(first_fail_idx), .miss_cnt(mismatch_cnt)
  );

  // R2: live operands and a finished run never coincide
  a_r2_valid_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !done);
endmodule

// File: tb/test_mbist_mult_top.sv
`timescale 1ns/1ps
module test_mbist_mult_top;
  localparam int MISS_W = 6;
  localparam int MAXM   = (1 << MISS_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pat_count = '0;
  logic [1:0]  lp_sel = '0;
  logic        op_valid, done, fail;
  logic [7:0]  op_a, op_b;
  logic [15:0] mut_product, first_fail_idx;
  logic [MISS_W-1:0] mismatch_cnt;

  int checks = 0, errors = 0;
  int f_lo = -1, f_hi = -1;

  // model state: 0 idle 1 seed 2 run 3 drain 4 done
  int m_st = 0, m_cnt = 0, m_lim = 0;
  bit m_lpa = 0, m_lpb = 0;
  logic [7:0] la = 8'hA5, pa = 8'hA5, lb = 8'h3C, pb = 8'h3C;
  logic [1:0] pha = 0, phb = 0;
  bit mq_vld = 0;
  logic [15:0] mq_mut = 0, mq_ref = 0;
  int mq_idx = 0;
  bit m_fail = 0;
  int m_first = 0, m_miss = 0;
  logic [7:0] obs_a [8];

  always #2.5 clk = ~clk;

  wire inj = (m_st == 2) && (m_cnt >= f_lo) && (m_cnt <= f_hi);
  assign mut_product = ({8'd0, op_a} * {8'd0, op_b}) ^ (inj ? 16'h0100 : 16'h0000);

  mbist_mult_top #(.MISS_W(MISS_W)) i_mbist_mult_top (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
    .lp_sel(lp_sel), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .mut_product(mut_product), .done(done), .fail(fail),
    .first_fail_idx(first_fail_idx), .mismatch_cnt(mismatch_cnt)
  );

  function automatic logic [17:0] gstep(logic [7:0] l, logic [7:0] p,
                                        logic [1:0] ph, bit lp);
    logic [7:0] n;
    n = {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
    if (!lp) return {n, n, 2'd0};
    case (ph)
      2'd0: return {n, p[7:4], p[3:0] & n[3:0], 2'd1};
      2'd1: return {l, p[7:4], l[3:0], 2'd2};
      2'd2: return {l, p[7:4] & l[7:4], p[3:0], 2'd3};
      default: return {l, l[7:4], p[3:0], 2'd0};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural cycle model
  always @(posedge clk) begin
    logic [17:0] ga, gb;
    if (rst_n) begin
      mq_vld <= (m_st == 2);
      if (m_st == 2) begin
        mq_mut <= mut_product;
        mq_ref <= {8'd0, pa} * {8'd0, pb};
        mq_idx <= m_cnt;
      end
      if (mq_vld && mq_mut != mq_ref) begin
        m_fail <= 1;
        if (!m_fail) m_first <= mq_idx;
        if (m_miss < MAXM) m_miss <= m_miss + 1;
      end
      case (m_st)
        0, 4: if (start) begin
          m_st <= 1; m_lim <= int'(pat_count);
          m_lpa <= lp_sel[0]; m_lpb <= lp_sel[1];
          m_fail <= 0; m_first <= 0; m_miss <= 0;
        end
        1: begin
          la <= 8'hA5; pa <= 8'hA5; pha <= 0;
          lb <= 8'h3C; pb <= 8'h3C; phb <= 0;
          m_cnt <= 0;
          m_st <= (m_lim == 0) ? 4 : 2;
        end
        2: begin
          ga = gstep(la, pa, pha, m_lpa);
          gb = gstep(lb, pb, phb, m_lpb);
          {la, pa, pha} <= ga;
          {lb, pb, phb} <= gb;
          m_cnt <= m_cnt + 1;
          if (m_cnt == m_lim - 1) m_st <= 3;
        end
        default: m_st <= 4;
      endcase
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!done && !fail && !op_valid && first_fail_idx == 0 && mismatch_cnt == 0,
          "R1 reset outputs", {done, fail, op_valid}, 0);
    end else begin
      chk(op_valid == (m_st == 2), "R2 op_valid", op_valid, m_st == 2);
      if (m_st == 2) begin
        chk(op_a == pa, m_lpa ? "R4 op_a lp" : "R3 op_a", op_a, pa);
        chk(op_b == pb, m_lpb ? "R4 op_b lp R10" : "R3 op_b R10", op_b, pb);
        if (m_cnt < 8) obs_a[m_cnt] = op_a;
      end
      chk(done == (m_st == 4), "R9 done", done, m_st == 4);
      chk(fail == m_fail, "R5 R6 fail", fail, m_fail);
      chk(int'(first_fail_idx) == m_first, "R7 first index", first_fail_idx, m_first);
      chk(int'(mismatch_cnt) == m_miss, "R8 count", mismatch_cnt, m_miss);
    end
  end

  task automatic run(input int n, input logic [1:0] lp, input int lo, input int hi);
    @(negedge clk);
    pat_count = 16'(n); lp_sel = lp; f_lo = lo; f_hi = hi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && !fail && mismatch_cnt == 0, "R1 idle after reset", done, 0);

    // plain run, with a start pulse and an lp_sel change mid-run (R2, R10)
    @(negedge clk);
    pat_count = 16'd20; lp_sel = 2'b00; f_lo = -1; f_hi = -1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1; lp_sel = 2'b11;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(obs_a[0] == 8'hA5, "R3 seed a", obs_a[0], 8'hA5);
    chk(obs_a[1] == 8'h4A, "R3 pattern1 a", obs_a[1], 8'h4A);
    chk(!fail && mismatch_cnt == 0, "R2 clean run", fail, 0);

    // low-switching on both generators
    run(40, 2'b11, -1, -1);
    chk(obs_a[1] == 8'hA0, "R4 lp pattern1", obs_a[1], 8'hA0);
    chk(obs_a[2] == 8'hAA, "R4 lp pattern2", obs_a[2], 8'hAA);
    chk(obs_a[3] == 8'h0A, "R4 lp pattern3", obs_a[3], 8'h0A);
    chk(obs_a[4] == 8'h4A, "R4 lp pattern4", obs_a[4], 8'h4A);

    // single fault
    run(30, 2'b00, 3, 3);
    chk(fail && first_fail_idx == 3 && mismatch_cnt == 1, "R7 single fault", first_fail_idx, 3);

    // burst fault, operand a low-switching only
    run(25, 2'b01, 5, 9);
    chk(first_fail_idx == 5 && mismatch_cnt == 5, "R8 burst count", mismatch_cnt, 5);

    // saturation
    run(100, 2'b10, 0, 99);
    chk(int'(mismatch_cnt) == MAXM, "R8 saturation", mismatch_cnt, MAXM);
    chk(first_fail_idx == 0 && fail, "R6 fail all", first_fail_idx, 0);

    // zero patterns, then a single faulty pattern
    run(0, 2'b00, -1, -1);
    chk(done && !fail, "R9 zero count", done, 1);
    run(1, 2'b00, 0, 0);
    chk(fail && mismatch_cnt == 1 && first_fail_idx == 0, "R5 last pattern drained", mismatch_cnt, 1);
    repeat (5) @(negedge clk);
    chk(done && fail, "R6 R9 hold", {done, fail}, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule